// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives a stereo serial audio stream whose timing is owned entirely by an external master. The bit clock and the word-select line are inputs only; the block never drives them. It oversamples the bit clock, word select, serial data and mute lines on a faster system clock. It finds the rising bit-clock edges and rebuilds one signed left sample and one signed right sample for every word-select period.

A two-bit static select picks the framing. One code selects the standard I2S layout, in which the MSB trails the word-select change by one bit and the word may be any length up to 24 bits. The other three codes select an LSB-justified layout with a 16, 20 or 24-bit word. Every word is delivered as a 24-bit two's-complement value. A stereo pair is handed over together with a one-cycle valid strobe. A mute input forces the delivered samples to zero for as long as it is held.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high, and in the cycle after it, both sample outputs are zero and the valid strobe is low.
- R2: With the select at 2'b00 (I2S), word select low carries the left word and high carries the right word. The MSB is the bit sampled on the second rising bit-clock edge after word select changes. The word ends with the bit sampled on the first rising edge after the next change. When the word has 24 bits or more, the first 24 bits received form the sample and the rest are dropped, so a 16-bit word padded with zeros in a 32-bit slot arrives shifted up by 8.
- R3: With the select at 2'b00, a word shorter than 24 bits is sign-extended from its own MSB.
- R4: With the select at 2'b01, 2'b10 or 2'b11 (LSB-justified with 16, 20 or 24 bits), the LSB is the bit sampled on the last rising bit-clock edge before word select changes. Only the final 16, 20 or 24 bits of the half-frame are kept, and they are sign-extended to 24 bits.
- R5: Left and right outputs change together, and valid is high for exactly one system-clock cycle each time a right word completes after a left word of the same frame. Each complete frame gives exactly one strobe.
- R6: After reset no sample is captured before the first word-select transition. A frame whose left word began before that transition produces no strobe, and the outputs stay at zero until the first complete frame.
- R7: While mute is held, both outputs read zero, including at the valid strobe. Once mute is released, the outputs show the last captured pair.
- R8: With mute steady low, the outputs hold their value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Bit clock from the external master |
| ws_i | input | 1 | Word select from the external master (low = left) |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_sel_i | input | 2 | Framing select: 00 I2S, 01/10/11 LSB-justified 16/20/24 |
| mute_i | input | 1 | Forces sample outputs to zero while high |
| left_o | output | SAMPLE_W | Left sample, two's complement |
| right_o | output | SAMPLE_W | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
A frame can complete in the same system-clock cycle in which mute changes, so the strobe and the mute forcing collide. The bench provokes this by toggling mute every few cycles, with a varying interval, while whole frames stream in. Mute then lands at every offset around the completion. At each strobe the bench looks at the mute level over the cycles that feed the output register. When that level was steady, the pair must equal zero (mute high) or the expected samples (mute low). When it changed inside the window, the pair must be one of the two and never a mixture.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ16 = 2'b01,
    FMT_LJ20 = 2'b10,
    FMT_LJ24 = 2'b11
  } fmt_e;

  // Word length kept in an LSB-justified mode.
  function automatic int unsigned lj_width(fmt_e f);
    case (f)
      FMT_LJ16: return 16;
      FMT_LJ20: return 20;
      default:  return 24;
    endcase
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= '0;
      else     ff <= {ff[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff[STAGES-1];
  end

endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_rise,
  input  logic          ws_s,
  input  logic          sd_s,
  input  fmt_e          fmt,
  output logic          word_done,
  output logic          word_chan,
  output logic [SW-1:0] word_data,
  output logic          locked
);

  localparam int CW = $clog2(SW + 1);

  logic          ws_last;
  logic          have_ws;
  logic          start_next;
  logic [SW-1:0] shreg;
  logic [CW-1:0] cnt;

  logic          toggle;
  logic [SW-1:0] i2s_val;
  logic [CW-1:0] i2s_len;
  logic [CW-1:0] lj_len;
  logic [SW-1:0] done_val;

  // Sign-extend the low n bits of v to the full width.
  function automatic logic [SW-1:0] sext(input logic [SW-1:0] v,
                                         input logic [CW-1:0] n);
    logic [SW-1:0] r;
    logic          s;
    s = v[n - 1'b1];
    for (int i = 0; i < SW; i++) r[i] = (CW'(i) < n) ? v[i] : s;
    return r;
  endfunction

  always_comb begin
    toggle = have_ws && (ws_s != ws_last);
    if (start_next) begin
      i2s_val = {{(SW-1){1'b0}}, sd_s};
      i2s_len = CW'(1);
    end else if (cnt < CW'(SW)) begin
      i2s_val = {shreg[SW-2:0], sd_s};
      i2s_len = cnt + 1'b1;
    end else begin
      i2s_val = shreg;
      i2s_len = CW'(SW);
    end
    lj_len   = CW'(lj_width(fmt));
    done_val = (fmt == FMT_I2S) ? sext(i2s_val, i2s_len) : sext(shreg, lj_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_last    <= 1'b0;
      have_ws    <= 1'b0;
      start_next <= 1'b0;
      locked     <= 1'b0;
      shreg      <= '0;
      cnt        <= '0;
      word_done  <= 1'b0;
      word_chan  <= 1'b0;
      word_data  <= '0;
    end else begin
      word_done <= 1'b0;
      if (bclk_rise) begin
        have_ws    <= 1'b1;
        ws_last    <= ws_s;
        start_next <= toggle;
        if (toggle) locked <= 1'b1;
        if (fmt == FMT_I2S) begin
          shreg <= i2s_val;
          cnt   <= i2s_len;
        end else begin
          shreg <= {shreg[SW-2:0], sd_s};
        end
        if (toggle && locked) begin
          word_done <= 1'b1;
          word_chan <= ws_last;
          word_data <= done_val;
        end
      end
    end
  end

endmodule

// File: rtl/sarx_frame.sv
module sarx_frame #(
  parameter int SW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_done,
  input  logic          word_chan,
  input  logic [SW-1:0] word_data,
  output logic [SW-1:0] held_l,
  output logic [SW-1:0] held_r,
  output logic          frame_stb
);

  logic [SW-1:0] left_buf;
  logic          left_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_buf  <= '0;
      left_pend <= 1'b0;
      held_l    <= '0;
      held_r    <= '0;
      frame_stb <= 1'b0;
    end else begin
      frame_stb <= 1'b0;
      if (word_done) begin
        if (!word_chan) begin
          left_buf  <= word_data;
          left_pend <= 1'b1;
        end else begin
          if (left_pend) begin
            held_l    <= left_buf;
            held_r    <= word_data;
            frame_stb <= 1'b1;
          end
          left_pend <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          fmt_sel_i,
  input  logic                mute_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0]    raw_in;
  logic [NSYNC-1:0]    synced;
  logic                bclk_s, ws_s, sd_s, mute_s;
  logic                bclk_d;
  logic                bclk_rise;
  fmt_e                fmt;
  logic                word_done, word_chan, locked;
  logic [SAMPLE_W-1:0] word_data;
  logic [SAMPLE_W-1:0] held_l, held_r;
  logic                frame_stb;

  assign raw_in = {mute_i, sd_i, ws_i, bclk_i};

  sarx_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (synced)
  );

  assign bclk_s = synced[0];
  assign ws_s   = synced[1];
  assign sd_s   = synced[2];
  assign mute_s = synced[3];
  assign fmt    = fmt_e'(fmt_sel_i);

  always_ff @(posedge clk) begin
    if (rst) bclk_d <= 1'b0;
    else     bclk_d <= bclk_s;
  end
  assign bclk_rise = bclk_s & ~bclk_d;

  sarx_deser #(.SW(SAMPLE_W)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .bclk_rise (bclk_rise),
    .ws_s      (ws_s),
    .sd_s      (sd_s),
    .fmt       (fmt),
    .word_done (word_done),
    .word_chan (word_chan),
    .word_data (word_data),
    .locked    (locked)
  );

  sarx_frame #(.SW(SAMPLE_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word_chan (word_chan),
    .word_data (word_data),
    .held_l    (held_l),
    .held_r    (held_r),
    .frame_stb (frame_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= frame_stb;
      left_o  <= mute_s ? '0 : held_l;
      right_o <= mute_s ? '0 : held_r;
    end
  end

endmodule

// File: rtl/sarx_checker.sv
module sarx_checker #(
  parameter int SW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          mute_s,
  input logic          frame_stb,
  input logic          locked,
  input logic [1:0]    fmt_sel_i,
  input logic [SW-1:0] left_o,
  input logic [SW-1:0] right_o,
  input logic          valid_o
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_o && left_o == '0 && right_o == '0));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r5_strobe_follows_frame: assert property (@(posedge clk) disable iff (rst)
    frame_stb |=> valid_o);

  a_r6_no_frame_unlocked: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !frame_stb);

  a_r7_mute_zero: assert property (@(posedge clk) disable iff (rst)
    mute_s |=> (left_o == '0 && right_o == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_stb && !mute_s && !$past(mute_s)) |=> ($stable(left_o) && $stable(right_o)));

  a_r4_lj16_sign: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fmt_sel_i == 2'b01) |->
      (right_o[SW-1:15] == '0 || right_o[SW-1:15] == '1));

  a_r4_lj20_sign: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fmt_sel_i == 2'b10) |->
      (left_o[SW-1:19] == '0 || left_o[SW-1:19] == '1));

endmodule

bind serial_audio_rx sarx_checker #(.SW(SAMPLE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mute_s    (mute_s),
  .frame_stb (frame_stb),
  .locked    (locked),
  .fmt_sel_i (fmt_sel_i),
  .left_o    (left_o),
  .right_o   (right_o),
  .valid_o   (valid_o)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;

  localparam int H = 3;  // system clocks per bit-clock phase

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, bclk, ws, sd, mute;
  logic [1:0]  fmt;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  serial_audio_rx dut_i (
    .clk(clk), .rst(rst), .bclk_i(bclk), .ws_i(ws), .sd_i(sd),
    .fmt_sel_i(fmt), .mute_i(mute),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  string       cur_req = "R1";
  logic [23:0] exp_l_q[$];
  logic [23:0] exp_r_q[$];
  logic [23:0] el, er;
  logic [3:0]  mute_hist = 4'h0;
  bit          prev_valid = 1'b0;
  logic        dly_bit = 1'b0;
  bit          finished = 1'b0;
  bit          race_stop;

  task automatic check(input string req, input string what,
                       input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: %s got %h expected %h", req, what, got, exp);
    end
  endtask

  // Strobe monitor: compares each delivered pair against the queue.
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (prev_valid) check("R5", "strobe width", 24'd2, 24'd1);
      if (exp_l_q.size() == 0) begin
        check(cur_req, "unexpected strobe", 24'd1, 24'd0);
      end else begin
        el = exp_l_q.pop_front();
        er = exp_r_q.pop_front();
        if (mute_hist == 4'hF) begin
          check("R7", "muted left", left_o, 24'd0);
          check("R7", "muted right", right_o, 24'd0);
        end else if (mute_hist == 4'h0) begin
          check(cur_req, "left", left_o, el);
          check(cur_req, "right", right_o, er);
        end else begin
          n_chk++;
          if (!((left_o == 24'd0 && right_o == 24'd0) ||
                (left_o == el && right_o == er))) begin
            n_bad++;
            $display("FAIL R7: mute race pair got %h/%h expected %h/%h or zero",
                     left_o, right_o, el, er);
          end
        end
      end
    end
    prev_valid = valid_o;
    mute_hist  = {mute_hist[2:0], mute};
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic slot(input logic w, input logic d);
    bclk = 1'b0; ws = w; sd = d;
    wait_cyc(H);
    bclk = 1'b1;
    wait_cyc(H);
  endtask

  task automatic half(input logic w, input logic [31:0] vec, input int s, input bit i2s);
    for (int t = 0; t < s; t++) begin
      logic b;
      b = vec[s-1-t];
      if (i2s) begin
        slot(w, dly_bit);
        dly_bit = b;
      end else begin
        slot(w, b);
      end
    end
  endtask

  function automatic logic [23:0] exp_i2s(input logic [31:0] v, input int s);
    logic [23:0] r;
    if (s >= 24) r = v[s-1 -: 24];
    else for (int i = 0; i < 24; i++) r[i] = (i < s) ? v[i] : v[s-1];
    return r;
  endfunction

  function automatic logic [23:0] exp_lj(input logic [31:0] v, input int n);
    logic [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  task automatic frame(input logic [31:0] l, input logic [31:0] r, input int s,
                       input bit i2s, input int n);
    if (i2s) begin
      exp_l_q.push_back(exp_i2s(l, s));
      exp_r_q.push_back(exp_i2s(r, s));
    end else begin
      exp_l_q.push_back(exp_lj(l, n));
      exp_r_q.push_back(exp_lj(r, n));
    end
    half(1'b0, l, s, i2s);
    half(1'b1, r, s, i2s);
  endtask

  task automatic tail(input string req);
    slot(1'b0, dly_bit);
    wait_cyc(20);
    check(req, "pending strobes", 24'(exp_l_q.size()), 24'd0);
  endtask

  task automatic start_stream(input logic [1:0] f, input logic ws_idle);
    rst = 1'b1; fmt = f; bclk = 1'b0; ws = ws_idle; sd = 1'b0; dly_bit = 1'b0;
    wait_cyc(4);
    exp_l_q.delete(); exp_r_q.delete();
    rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic test_reset();
    cur_req = "R1";
    rst = 1'b1;
    wait_cyc(3);
    check("R1", "left in reset", left_o, 24'd0);
    check("R1", "right in reset", right_o, 24'd0);
    check("R1", "valid in reset", 24'(valid_o), 24'd0);
    rst = 1'b0;
    wait_cyc(1);
    check("R1", "left after reset", left_o, 24'd0);
  endtask

  task automatic test_i2s_long();
    start_stream(2'b00, 1'b1);
    cur_req = "R2";
    for (int k = 0; k < 4; k++) slot(1'b1, 1'b0);
    frame(32'hABCDEF00, 32'h12345600, 32, 1'b1, 0);
    frame(32'h80010000, 32'h7FFF0000, 32, 1'b1, 0);  // 16-bit words, padded
    frame(32'hF1234567, 32'h0ABCDEF9, 32, 1'b1, 0);  // 28+ bit words, truncated
    tail("R2");
  endtask

  task automatic test_i2s_short();
    start_stream(2'b00, 1'b1);
    cur_req = "R3";
    for (int k = 0; k < 4; k++) slot(1'b1, 1'b0);
    frame(32'h00008003, 32'h00001234, 16, 1'b1, 0);
    frame(32'h000F0F0F, 32'h0007AAAA, 20, 1'b1, 0);
    frame(32'h00000001, 32'h0000FFFE, 16, 1'b1, 0);
    tail("R3");
  endtask

  task automatic test_lj(input logic [1:0] f, input int n);
    start_stream(f, 1'b1);
    cur_req = "R4";
    for (int k = 0; k < 4; k++) slot(1'b1, 1'b0);
    frame(32'hA5C37E42, 32'h5A3C81BD, 32, 1'b0, n);
    frame(32'hFFFF0123, 32'h00F8FEDC, 32, 1'b0, n);
    tail("R4");
  endtask

  task automatic test_startup();
    start_stream(2'b11, 1'b0);
    cur_req = "R6";
    for (int k = 0; k < 10; k++) slot(1'b0, 1'b1);   // partial left before lock
    half(1'b1, 32'h00765432, 32, 1'b0);              // right with no left: dropped
    check("R6", "left before first frame", left_o, 24'd0);
    check("R6", "right before first frame", right_o, 24'd0);
    frame(32'h00135790, 32'h00FEDCBA, 32, 1'b0, 24);
    tail("R6");
  endtask

  task automatic test_mute_hold();
    logic [23:0] l1, r1;
    start_stream(2'b11, 1'b1);
    cur_req = "R7";
    l1 = 24'h4C4C01; r1 = 24'hB3B302;
    mute = 1'b1;
    wait_cyc(6);
    for (int k = 0; k < 4; k++) slot(1'b1, 1'b0);
    frame({8'h00, l1}, {8'h00, r1}, 32, 1'b0, 24);
    tail("R7");
    check("R7", "left while muted", left_o, 24'd0);
    check("R7", "right while muted", right_o, 24'd0);
    mute = 1'b0;
    wait_cyc(6);
    check("R7", "left after unmute", left_o, l1);
    check("R7", "right after unmute", right_o, r1);
    for (int k = 0; k < 5; k++) begin
      wait_cyc(10);
      check("R8", "left hold", left_o, l1);
      check("R8", "right hold", right_o, r1);
      check("R8", "no strobe", 24'(valid_o), 24'd0);
    end
  endtask

  task automatic test_mute_race();
    start_stream(2'b01, 1'b1);
    cur_req = "R7";
    race_stop = 1'b0;
    for (int k = 0; k < 4; k++) slot(1'b1, 1'b0);
    fork
      begin
        frame(32'h00001357, 32'h0000ACE0, 32, 1'b0, 16);
        frame(32'h00009ABC, 32'h00000042, 32, 1'b0, 16);
        frame(32'h00007FFF, 32'h00008000, 32, 1'b0, 16);
        frame(32'h0000F00D, 32'h00000BAD, 32, 1'b0, 16);
        tail("R7");
        race_stop = 1'b1;
      end
      begin
        int k;
        k = 0;
        while (!race_stop) begin
          wait_cyc(3 + (k % 4));
          mute = ~mute;
          k++;
        end
        mute = 1'b0;
      end
    join
    wait_cyc(6);
  endtask

  initial begin
    rst = 1'b1; fmt = 2'b00; bclk = 1'b0; ws = 1'b1; sd = 1'b0; mute = 1'b0;
    test_reset();
    test_i2s_long();
    test_i2s_short();
    test_lj(2'b01, 16);
    test_lj(2'b10, 20);
    test_lj(2'b11, 24);
    test_reset();
    test_startup();
    test_mute_hold();
    test_mute_race();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (%s): cycles got 200000 expected fewer", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule